// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside a two-bank synchronous DRAM command bus. On every rising clock edge it samples the chip-select, the three strobes, clock enable, bank select and the eleven address lines. It turns each legal pattern into a one-cycle command pulse and keeps a model of which banks hold an open row and which row that is. A command that breaks the bank rules raises a one-cycle error pulse and leaves the tracked state as it was.

The block also holds the mode settings: latency, burst length, wrap type and single-write mode. With these it counts down an auto-precharge that a read or write requested on address bit 8. The same bit, on a precharge, widens the close to every bank. The point at which a read closes its bank is counted from the latency and the burst length. A write closes its bank a fixed recovery delay after its last data beat.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip-select low and clock enable high, the strobe pattern {ras,cas,we} gives: 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 001 refresh, 110 burst stop, 111 no command. An accepted command shows on `cmd_o` for the one cycle after the sampling edge, as a single bit: 0 activate, 1 read, 2 write, 3 precharge, 4 mode set, 5 refresh, 6 self refresh, 7 burst stop.
- R2: While chip-select is high, no command pulse and no error appear, and the bank state and rows stay unchanged.
- R3: While clock enable is low, only the refresh pattern is decoded, and it is decoded as self refresh. Every other pattern is ignored without an error.
- R4: An activate to an idle bank opens it and latches address bits 10..0 as its row. Bank b's row is on `row_o[b*11 +: 11]` and its open flag on `bank_open_o[b]`.
- R5: An activate to an open bank, or a read or write to an idle bank, produces an `err_o` pulse and no command pulse, and leaves that bank's state and row unchanged.
- R6: A precharge with address bit 8 low closes the bank chosen by `ba_i`. With bit 8 high it closes both banks. A precharge to an idle bank is accepted.
- R7: A mode set is accepted only when both banks are idle, clock enable was high at the previous edge and the fields are legal. The fields are: bits 6..4 latency (010 = 2, 011 = 3), bits 2..0 burst length (000/001/010/011 = 1/2/4/8, 111 = full page), bit 3 interleave and bit 9 single write. Full page together with interleave is illegal. Any failed condition gives an error and keeps the old settings.
- R8: Refresh and self refresh are accepted only when both banks are idle, otherwise they produce an error.
- R9: A read with address bit 8 high closes its bank at the edge that comes burst-length edges after the read's edge. This is one edge before the last data at latency 2 and two edges before it at latency 3.
- R10: A write with address bit 8 high closes its bank (W-1)+TWR edges after the write's edge. W is the burst length, or 1 in single-write mode, and TWR defaults to 2.
- R11: While a bank's auto-precharge is pending, a read, write or activate to that bank is an error. An explicit precharge closes it at once and cancels the pending close.
- R12: When an auto-precharge closes a bank on the same edge that a command arrives, the command is judged on the state before that edge.
- R13: In full-page mode address bit 8 schedules no auto-precharge on a read, and none on a write unless single-write mode is set.
- R14: After reset both banks are idle, rows are zero, `cmd_o` and `err_o` are low, and the mode is latency 3, burst length 1, sequential, burst writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 1 | Bank select |
| addr_i | input | 11 | Row, column, auto-precharge and mode fields |
| cmd_o | output | 8 | One-hot accepted command pulse |
| bank_open_o | output | 2 | Per-bank open flag |
| row_o | output | 22 | Per-bank open row, 11 bits each |
| err_o | output | 1 | Illegal command pulse |

## Verification
An auto-precharge countdown can expire on the same edge that a new command arrives. The bench sets up this collision by programming a two-beat burst, issuing a read with auto-precharge, and placing an activate exactly two edges later. If the activate targets the same bank it must be flagged as an error and the bank must end up closed. If it targets the other bank it must be accepted while the first bank closes, so that the open flags flip together.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int unsigned NUM_CMD = 8;
  localparam int unsigned B_ACT  = 0;
  localparam int unsigned B_RD   = 1;
  localparam int unsigned B_WR   = 2;
  localparam int unsigned B_PRE  = 3;
  localparam int unsigned B_MRS  = 4;
  localparam int unsigned B_REF  = 5;
  localparam int unsigned B_SREF = 6;
  localparam int unsigned B_BST  = 7;

  typedef enum logic [3:0] {
    K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_MRS, K_REF, K_SREF, K_BST
  } cmd_kind_e;

  function automatic logic [NUM_CMD-1:0] kind_onehot(cmd_kind_e k);
    logic [NUM_CMD-1:0] v;
    v = '0;
    case (k)
      K_ACT:   v[B_ACT]  = 1'b1;
      K_RD:    v[B_RD]   = 1'b1;
      K_WR:    v[B_WR]   = 1'b1;
      K_PRE:   v[B_PRE]  = 1'b1;
      K_MRS:   v[B_MRS]  = 1'b1;
      K_REF:   v[B_REF]  = 1'b1;
      K_SREF:  v[B_SREF] = 1'b1;
      K_BST:   v[B_BST]  = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic      cs_ni,
  input  logic      ras_ni,
  input  logic      cas_ni,
  input  logic      we_ni,
  input  logic      cke_i,
  output cmd_kind_e kind_o
);

  logic [2:0] strobes;
  assign strobes = {ras_ni, cas_ni, we_ni};

  always_comb begin
    kind_o = K_NOP;
    if (!cs_ni) begin
      if (cke_i) begin
        case (strobes)
          3'b011:  kind_o = K_ACT;
          3'b101:  kind_o = K_RD;
          3'b100:  kind_o = K_WR;
          3'b010:  kind_o = K_PRE;
          3'b000:  kind_o = K_MRS;
          3'b001:  kind_o = K_REF;
          3'b110:  kind_o = K_BST;
          default: kind_o = K_NOP;
        endcase
      end else if (strobes == 3'b001) begin
        // clock enable low: only self-refresh entry is meaningful
        kind_o = K_SREF;
      end
    end
  end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       lat_code_i,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             single_i,
  output logic             code_ok_o,
  output logic [1:0]       cl_o,
  output logic [LEN_W-1:0] len_o,
  output logic             full_o,
  output logic             single_o
);

  logic       lat_ok, len_ok, is_full;
  logic [1:0] cl_q;
  logic [LEN_W-1:0] len_q;
  logic       full_q, single_q;

  assign lat_ok    = (lat_code_i == 3'b010) || (lat_code_i == 3'b011);
  assign is_full   = (len_code_i == 3'b111);
  assign len_ok    = !len_code_i[2] || (is_full && !ilv_i);
  assign code_ok_o = lat_ok && len_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_q     <= 2'd3;
      len_q    <= LEN_W'(1);
      full_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (load_i) begin
      cl_q     <= lat_code_i[0] ? 2'd3 : 2'd2;
      len_q    <= LEN_W'(1) << len_code_i[1:0];
      full_q   <= is_full;
      single_q <= single_i;
    end
  end

  assign cl_o     = cl_q;
  assign len_o    = len_q;
  assign full_o   = full_q;
  assign single_o = single_q;

  // R7
  cl_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_q[1] == 1'b1);

  // R7
  load_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> code_ok_o);

endmodule

// File: rtl/sdram_bank.sv
module sdram_bank #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             ap_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);

  logic             open_q, pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (pre_i) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (ap_i) begin
      pend_q <= 1'b1;
      cnt_q  <= dly_i - CNT_W'(1);
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign open_o = open_q;
  assign pend_o = pend_q;
  assign row_o  = row_q;

  // R9
  ap_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && cnt_q == '0 && !pre_i) |=> !open_q);

  // R4
  act_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_q && row_q == $past(row_i)));

  // R11
  pend_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> open_q);

  // R6
  pre_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> (!open_q && !pend_q));

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned TWR       = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_ni,
  input  logic                          ras_ni,
  input  logic                          cas_ni,
  input  logic                          we_ni,
  input  logic                          cke_i,
  input  logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] ba_i,
  input  logic [ADDR_W-1:0]             addr_i,
  output logic [NUM_CMD-1:0]            cmd_o,
  output logic [NUM_BANKS-1:0]          bank_open_o,
  output logic [NUM_BANKS*ADDR_W-1:0]   row_o,
  output logic                          err_o
);

  localparam int unsigned BA_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned ROW_W  = ADDR_W;
  localparam int unsigned AP_BIT = COL_W;
  localparam int unsigned CNT_W  = $clog2(8 + TWR + 1);

  cmd_kind_e            kind;
  logic                 cke_q;
  logic [NUM_CMD-1:0]   cmd_q;
  logic                 err_q;
  logic [NUM_BANKS-1:0] open_v, pend_v, sel_v, act_g, pre_g, ap_g;
  logic                 all_idle, legal, take, ap_req, mrs_load, code_ok;
  logic [1:0]           cl;
  logic [CNT_W-1:0]     len, cl_w, rd_dly, wr_dly, wlen, ap_dly;
  logic                 full_pg, single_wr;

  sdram_cmd_decode u_dec (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cke_i  (cke_i),
    .kind_o (kind)
  );

  assign mrs_load = take && (kind == K_MRS);

  sdram_mode_reg #(.LEN_W(CNT_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (mrs_load),
    .lat_code_i (addr_i[6:4]),
    .len_code_i (addr_i[2:0]),
    .ilv_i      (addr_i[3]),
    .single_i   (addr_i[9]),
    .code_ok_o  (code_ok),
    .cl_o       (cl),
    .len_o      (len),
    .full_o     (full_pg),
    .single_o   (single_wr)
  );

  assign all_idle = ~|open_v;

  always_comb begin
    case (kind)
      K_ACT:        legal = !open_v[ba_i];
      K_RD, K_WR:   legal = open_v[ba_i] && !pend_v[ba_i];
      K_MRS:        legal = all_idle && cke_q && code_ok;
      K_REF, K_SREF: legal = all_idle;
      default:      legal = 1'b1;
    endcase
  end

  assign take = legal && (kind != K_NOP);

  // read: last beat at CL+BL-1, close leads it by CL-1 edges
  assign cl_w   = CNT_W'(cl);
  assign rd_dly = (cl_w + len - CNT_W'(1)) - (cl_w - CNT_W'(1));
  assign wlen   = single_wr ? CNT_W'(1) : len;
  assign wr_dly = wlen - CNT_W'(1) + CNT_W'(TWR);
  assign ap_dly = (kind == K_WR) ? wr_dly : rd_dly;
  assign ap_req = addr_i[AP_BIT] &&
                  (((kind == K_RD) && !full_pg) ||
                   ((kind == K_WR) && (single_wr || !full_pg)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel_v[b] = (ba_i == BA_W'(b));
    assign act_g[b] = take && (kind == K_ACT) && sel_v[b];
    assign pre_g[b] = take && (kind == K_PRE) && (addr_i[AP_BIT] || sel_v[b]);
    assign ap_g[b]  = take && ((kind == K_RD) || (kind == K_WR)) && sel_v[b] && ap_req;

    sdram_bank #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act_g[b]),
      .pre_i  (pre_g[b]),
      .ap_i   (ap_g[b]),
      .dly_i  (ap_dly),
      .row_i  (addr_i[ROW_W-1:0]),
      .open_o (open_v[b]),
      .pend_o (pend_v[b]),
      .row_o  (row_o[b*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q <= 1'b0;
      cmd_q <= '0;
      err_q <= 1'b0;
    end else begin
      cke_q <= cke_i;
      cmd_q <= take ? kind_onehot(kind) : '0;
      err_q <= (kind != K_NOP) && !legal;
    end
  end

  assign cmd_o       = cmd_q;
  assign err_o       = err_q;
  assign bank_open_o = open_v;

  // R1
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));

  // R2
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == '0 && !err_o));

  // R5
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cmd_o == '0));

  // R7
  mrs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[B_MRS] |-> (bank_open_o == '0));

  // R8
  ref_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[B_REF] || cmd_o[B_SREF]) |-> (bank_open_o == '0));

  // R4
  act_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[B_ACT] |-> (bank_open_o != '0));

endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;

  localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                         S_PRE = 3'b010, S_MRS = 3'b000, S_REF = 3'b001,
                         S_BST = 3'b110, S_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [0:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [7:0]  cmd;
  logic [1:0]  bopen;
  logic [21:0] rows;
  logic        err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cs_ni       (cs_n),
    .ras_ni      (ras_n),
    .cas_ni      (cas_n),
    .we_ni       (we_n),
    .cke_i       (cke),
    .ba_i        (ba),
    .addr_i      (addr),
    .cmd_o       (cmd),
    .bank_open_o (bopen),
    .row_o       (rows),
    .err_o       (err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at a negedge, let one rising edge sample, return at the next negedge
  task automatic drv(input logic [2:0] s, input logic b, input logic [10:0] a,
                     input logic ck = 1'b1, input logic csn = 1'b0);
    {ras_n, cas_n, we_n} = s;
    ba = b; addr = a; cke = ck; cs_n = csn;
    @(negedge clk);
    {ras_n, cas_n, we_n} = S_NOP;
    cke = 1'b1; cs_n = 1'b0; addr = '0; ba = '0;
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) drv(S_NOP, 1'b0, 11'h000);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R14 cmd", cmd, 0);
    chk("R14 err", err, 0);
    chk("R14 open", bopen, 0);
    chk("R14 rows", rows, 0);
  endtask

  task automatic t_decode;
    drv(S_MRS, 0, 11'h032);
    chk("R1 R7 mrs", cmd, 8'h10);
    drv(S_ACT, 0, 11'h155);
    chk("R1 act", cmd, 8'h01);
    chk("R4 open", bopen, 2'b01);
    chk("R4 row0", rows[10:0], 11'h155);
    drv(S_ACT, 1, 11'h2AA);
    chk("R4 open both", bopen, 2'b11);
    chk("R4 row1", rows[21:11], 11'h2AA);
    drv(S_RD, 0, 11'h012);
    chk("R1 rd", cmd, 8'h02);
    drv(S_WR, 1, 11'h034);
    chk("R1 wr", cmd, 8'h04);
    drv(S_BST, 0, 11'h000);
    chk("R1 bst", cmd, 8'h80);
    drv(S_NOP, 0, 11'h000);
    chk("R1 nop", cmd, 8'h00);
    chk("R1 still open", bopen, 2'b11);
  endtask

  task automatic t_cs;
    drv(S_PRE, 0, 11'h100, 1'b1, 1'b1);
    chk("R2 cmd", cmd, 0);
    chk("R2 err", err, 0);
    chk("R2 open", bopen, 2'b11);
  endtask

  task automatic t_cke;
    drv(S_PRE, 0, 11'h100, 1'b0);
    chk("R3 pre ignored", cmd, 0);
    chk("R3 no err", err, 0);
    chk("R3 open", bopen, 2'b11);
    drv(S_ACT, 0, 11'h0F0, 1'b0);
    chk("R3 act ignored err", err, 0);
    chk("R3 row kept", rows[10:0], 11'h155);
  endtask

  task automatic t_illegal;
    drv(S_ACT, 0, 11'h0F0);
    chk("R5 act open err", err, 1);
    chk("R5 act no cmd", cmd, 0);
    chk("R5 row kept", rows[10:0], 11'h155);
    drv(S_MRS, 0, 11'h032);
    chk("R7 mrs open err", err, 1);
    drv(S_REF, 0, 11'h000);
    chk("R8 ref open err", err, 1);
    drv(S_PRE, 1, 11'h000);
    chk("R6 pre one cmd", cmd, 8'h08);
    chk("R6 pre one open", bopen, 2'b01);
    drv(S_RD, 1, 11'h000);
    chk("R5 rd idle err", err, 1);
    chk("R5 rd idle open", bopen, 2'b01);
    drv(S_WR, 1, 11'h000);
    chk("R5 wr idle err", err, 1);
    drv(S_PRE, 1, 11'h000);
    chk("R6 pre idle ok", cmd, 8'h08);
    chk("R6 pre idle noerr", err, 0);
    drv(S_PRE, 0, 11'h100);
    chk("R6 pre all", bopen, 2'b00);
    drv(S_REF, 0, 11'h000);
    chk("R8 ref ok", cmd, 8'h20);
    drv(S_REF, 0, 11'h000, 1'b0);
    chk("R3 R8 sref", cmd, 8'h40);
    drv(S_MRS, 0, 11'h032);
    chk("R7 mrs cke low before", err, 1);
    drv(S_MRS, 0, 11'h000);
    chk("R7 mrs bad latency", err, 1);
    drv(S_MRS, 0, 11'h03F);
    chk("R7 mrs full interleave", err, 1);
    drv(S_MRS, 0, 11'h032);
    chk("R7 mrs ok", cmd, 8'h10);
  endtask

  task automatic t_ap_read;
    drv(S_MRS, 0, 11'h022);
    drv(S_ACT, 0, 11'h001);
    drv(S_RD, 0, 11'h100);
    chk("R9 rd cmd", cmd, 8'h02);
    nops(3);
    chk("R9 cl2 bl4 open", bopen, 2'b01);
    nops(1);
    chk("R9 cl2 bl4 closed", bopen, 2'b00);
    drv(S_MRS, 0, 11'h033);
    drv(S_ACT, 0, 11'h002);
    drv(S_RD, 0, 11'h105);
    nops(7);
    chk("R9 cl3 bl8 open", bopen, 2'b01);
    nops(1);
    chk("R9 cl3 bl8 closed", bopen, 2'b00);
  endtask

  task automatic t_ap_write;
    drv(S_MRS, 0, 11'h032);
    drv(S_ACT, 1, 11'h003);
    drv(S_WR, 1, 11'h100);
    nops(4);
    chk("R10 bl4 open", bopen, 2'b10);
    nops(1);
    chk("R10 bl4 closed", bopen, 2'b00);
    drv(S_MRS, 0, 11'h232);
    drv(S_ACT, 1, 11'h004);
    drv(S_WR, 1, 11'h100);
    nops(1);
    chk("R10 single open", bopen, 2'b10);
    nops(1);
    chk("R10 single closed", bopen, 2'b00);
  endtask

  task automatic t_pending;
    drv(S_MRS, 0, 11'h033);
    drv(S_ACT, 0, 11'h005);
    drv(S_RD, 0, 11'h100);
    drv(S_RD, 0, 11'h000);
    chk("R11 rd pend err", err, 1);
    drv(S_ACT, 0, 11'h006);
    chk("R11 act pend err", err, 1);
    drv(S_WR, 0, 11'h000);
    chk("R11 wr pend err", err, 1);
    drv(S_PRE, 0, 11'h000);
    chk("R11 pre cmd", cmd, 8'h08);
    chk("R11 pre closes", bopen, 2'b00);
    drv(S_ACT, 0, 11'h007);
    nops(6);
    chk("R11 cancelled", bopen, 2'b01);
    drv(S_PRE, 0, 11'h100);
  endtask

  task automatic t_collide;
    drv(S_MRS, 0, 11'h021);
    drv(S_ACT, 0, 11'h008);
    drv(S_RD, 0, 11'h100);
    nops(1);
    drv(S_ACT, 0, 11'h009);
    chk("R12 same bank err", err, 1);
    chk("R12 same bank closed", bopen, 2'b00);
    chk("R12 row kept", rows[10:0], 11'h008);
    drv(S_ACT, 0, 11'h00A);
    chk("R12 reopen", cmd, 8'h01);
    drv(S_RD, 0, 11'h100);
    nops(1);
    drv(S_ACT, 1, 11'h00B);
    chk("R12 other bank cmd", cmd, 8'h01);
    chk("R12 other bank open", bopen, 2'b10);
    drv(S_PRE, 0, 11'h100);
  endtask

  task automatic t_fullpage;
    drv(S_MRS, 0, 11'h027);
    chk("R7 R13 mrs full", cmd, 8'h10);
    drv(S_ACT, 0, 11'h00C);
    drv(S_RD, 0, 11'h100);
    nops(10);
    chk("R13 rd stays open", bopen, 2'b01);
    drv(S_WR, 0, 11'h100);
    nops(10);
    chk("R13 wr stays open", bopen, 2'b01);
    drv(S_PRE, 0, 11'h100);
    chk("R6 final close", bopen, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_cs();
    t_cke();
    t_illegal();
    t_ap_read();
    t_ap_write();
    t_pending();
    t_collide();
    t_fullpage();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule